// File: doc/BRIEF.md
# Frequency-Change Watchdog Recovery Controller

This block supervises output-frequency changes in a programmable clock generator. Each accepted change to the frequency selection can arm a countdown watchdog. Software shows that the system is still alive after the change by sending heartbeat strobes. If the countdown expires first, the block forces a fixed recovery selection, latches a timeout status bit and locks out further frequency requests until software drops the watchdog enable.

A single control byte is written and read through a simple register port. It holds three enables, a write-one-to-clear timeout flag and a read-only recovery flag. A system reset pulse of fixed length can be raised on a timeout, on an accepted frequency change, or on both. The countdown runs on a prescaled time base, so long timeouts need only a small counter.

Top module: `fcwd_ctrl`

## Requirements
- R1: After reset, `reg_rdata_o` is 0, `freq_sel_o` is 0, `sys_rst_o` is 0 and `recov_o` is 0.
- R2: The control byte layout is as follows. Bit 0 is the watchdog enable, bit 1 is reset-on-timeout, bit 2 is reset-on-change, bit 3 is the timeout status, and bit 4 is the recovery flag, which is read only. Bits 7..5 always read 0. A write stores bits 2..0 on the next clock edge.
- R3: A frequency request (`chg_req_i` high at a clock edge) is accepted when the block is not in recovery. `freq_sel_o` takes `chg_sel_i` after that edge.
- R4: The countdown runs only when the watchdog enable is 1 and a change has been accepted while it was set. Timeout falls RELOAD*PRESCALE clock edges after the accepting edge. With the enable at 0, or with no change since it was set, no timeout occurs.
- R5: A heartbeat (`kick_i`) while the countdown runs restarts it, so the timeout falls RELOAD*PRESCALE edges after the last heartbeat. A heartbeat while the countdown is stopped has no effect.
- R6: On timeout, `freq_sel_o` becomes RECOV_SEL, `recov_o` and the recovery bit go to 1, and the status bit is set.
- R7: Writing 1 to status bit 3 clears it. Writing 0 to it leaves it unchanged.
- R8: While in recovery, frequency requests change nothing: `freq_sel_o` stays the same and no reset pulse is raised.
- R9: When the watchdog enable reads 0, recovery ends on the following edge and the countdown is stopped. `freq_sel_o` keeps RECOV_SEL until a new change is accepted.
- R10: A timeout raises `sys_rst_o` for PULSE_LEN cycles only if reset-on-timeout is set.
- R11: An accepted change raises `sys_rst_o` for PULSE_LEN cycles, starting after the accepting edge, if reset-on-change is set.
- R12: A new pulse trigger during an active pulse restarts the full length. The pulses merge into one longer pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Control byte read data |
| chg_req_i | input | 1 | Frequency change request |
| chg_sel_i | input | SEL_W | Requested frequency selection |
| kick_i | input | 1 | Software heartbeat, restarts the countdown |
| freq_sel_o | output | SEL_W | Active frequency selection |
| sys_rst_o | output | 1 | System reset pulse |
| recov_o | output | 1 | Recovery mode active |

## Verification
Register writes and accepted changes show at the outputs one edge after the strobe. The reset pulse rises on that same edge and stays high for exactly PULSE_LEN samples. A timeout shows exactly RELOAD*PRESCALE edges after the accepting edge or the last heartbeat, and leaving recovery takes one edge more than the write that clears the enable. All inputs are driven and all outputs sampled on the falling edge. Each timing check samples one cycle before the due edge, expecting the old value, and then on the due edge, expecting the new one. Pulse lengths are measured by counting high samples over a window wider than the pulse.

// File: rtl/fcwd_pkg.sv
package fcwd_pkg;
  localparam int unsigned CTL_W      = 8;
  localparam int unsigned B_WD_EN    = 0;
  localparam int unsigned B_RST_WD   = 1;
  localparam int unsigned B_RST_CHG  = 2;
  localparam int unsigned B_STS      = 3;
  localparam int unsigned B_RECOV    = 4;

  typedef struct packed {
    logic wd_en;
    logic rst_wd;
    logic rst_chg;
  } ctl_t;
endpackage

// File: rtl/fcwd_timer.sv
module fcwd_timer #(
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned RELOAD   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic kick_i,
  output logic run_o,
  output logic expire_o
);
  localparam int unsigned PRE_W = $clog2(PRESCALE + 1);
  localparam int unsigned CNT_W = $clog2(RELOAD + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RELOAD);

  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, load;

  assign tick     = (pre_q == PRE_LAST);
  assign load     = start_i || (kick_i && run_q);
  assign expire_o = en_i && run_q && !load && tick && (cnt_q == CNT_W'(1));
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= CNT_INIT;
    end else if (!en_i) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= CNT_INIT;
    end else if (load) begin
      run_q <= 1'b1;
      pre_q <= '0;
      cnt_q <= CNT_INIT;
    end else if (run_q) begin
      if (tick) begin
        pre_q <= '0;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          cnt_q <= CNT_INIT;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  p_stop_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !run_q);
  p_kick_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && kick_i) |=> (run_q && cnt_q == CNT_INIT && pre_q == '0));
endmodule

// File: rtl/fcwd_pulse.sv
module fcwd_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned W = $clog2(LEN + 1);

  logic [W-1:0] cnt_q;

  assign pulse_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (trig_i)     cnt_q <= W'(LEN);  // retrigger restarts full length
    else if (cnt_q != 0) cnt_q <= cnt_q - W'(1);
  end

  p_extend_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && pulse_o) |=> pulse_o);
endmodule

// File: rtl/fcwd_ctrl.sv
module fcwd_ctrl
  import fcwd_pkg::*;
#(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned PRESCALE  = 16,
  parameter int unsigned RELOAD    = 16,
  parameter int unsigned PULSE_LEN = 4,
  parameter logic [SEL_W-1:0] RECOV_SEL = SEL_W'(5)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             chg_req_i,
  input  logic [SEL_W-1:0] chg_sel_i,
  input  logic             kick_i,
  output logic [SEL_W-1:0] freq_sel_o,
  output logic             sys_rst_o,
  output logic             recov_o
);
  ctl_t             ctl_q;
  logic             sts_q, recov_q;
  logic [SEL_W-1:0] freq_sel_q;
  logic             accept, expire, run, trig;

  assign accept = chg_req_i && !recov_q;

  fcwd_timer #(.PRESCALE(PRESCALE), .RELOAD(RELOAD)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctl_q.wd_en),
    .start_i (accept),
    .kick_i  (kick_i),
    .run_o   (run),
    .expire_o(expire)
  );

  assign trig = (expire && ctl_q.rst_wd) || (accept && ctl_q.rst_chg);

  fcwd_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .pulse_o(sys_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      sts_q      <= 1'b0;
      recov_q    <= 1'b0;
      freq_sel_q <= '0;
    end else begin
      if (reg_we_i) begin
        ctl_q.wd_en   <= reg_wdata_i[B_WD_EN];
        ctl_q.rst_wd  <= reg_wdata_i[B_RST_WD];
        ctl_q.rst_chg <= reg_wdata_i[B_RST_CHG];
      end
      if (expire)                              sts_q <= 1'b1;
      else if (reg_we_i && reg_wdata_i[B_STS]) sts_q <= 1'b0;
      if (expire)            recov_q <= 1'b1;
      else if (!ctl_q.wd_en) recov_q <= 1'b0;
      if (expire)      freq_sel_q <= RECOV_SEL;
      else if (accept) freq_sel_q <= chg_sel_i;
    end
  end

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[B_WD_EN]   = ctl_q.wd_en;
    reg_rdata_o[B_RST_WD]  = ctl_q.rst_wd;
    reg_rdata_o[B_RST_CHG] = ctl_q.rst_chg;
    reg_rdata_o[B_STS]     = sts_q;
    reg_rdata_o[B_RECOV]   = recov_q;
  end

  assign freq_sel_o = freq_sel_q;
  assign recov_o    = recov_q;

  p_timeout_recov_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (recov_q && sts_q && freq_sel_q == RECOV_SEL));
  p_ignore_in_recov_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recov_q && chg_req_i) |=> $stable(freq_sel_q));
  p_leave_recov_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.wd_en |=> (!recov_q && !run));
  p_rst_on_wd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ctl_q.rst_wd) |=> sys_rst_o);
  p_rst_on_chg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && ctl_q.rst_chg) |=> sys_rst_o);
endmodule

// File: tb/fcwd_ctrl_tb.sv
module fcwd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 3;
  localparam int PRE = 4;
  localparam int REL = 6;
  localparam int LEN = 3;
  localparam int N = PRE * REL;
  localparam logic [SEL_W-1:0] RSEL = 3'd5;

  logic clk = 0, rst_n = 0;
  logic we = 0, req = 0, kick = 0;
  logic [7:0] wdata = 0, rdata;
  logic [SEL_W-1:0] sel = 0, fsel;
  logic srst, recov;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcwd_ctrl #(.SEL_W(SEL_W), .PRESCALE(PRE), .RELOAD(REL), .PULSE_LEN(LEN),
              .RECOV_SEL(RSEL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .chg_req_i(req), .chg_sel_i(sel), .kick_i(kick),
    .freq_sel_o(fsel), .sys_rst_o(srst), .recov_o(recov));

  task automatic chk(string req_s, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_s, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    we = 1; wdata = d; cyc(1); we = 0;
  endtask

  task automatic change(logic [SEL_W-1:0] s);
    req = 1; sel = s; cyc(1); req = 0;
  endtask

  // counts high samples of srst: the current one and n-1 further
  task automatic count_high(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) cyc(1);
      if (srst) highs++;
    end
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 0);
    chk("R1 freq_sel", fsel, 0);
    chk("R1 sys_rst", srst, 0);
    chk("R1 recov", recov, 0);
  endtask

  task automatic t_regs;
    wr(8'h07);
    chk("R2 readback", rdata, 8'h07);
    wr(8'hFF);
    chk("R2 upper bits and status write", rdata, 8'h07);
    wr(8'h00);
    chk("R2 cleared", rdata, 8'h00);
  endtask

  task automatic t_no_watchdog;
    change(3'd3);
    chk("R3 freq updated", fsel, 3);
    cyc(N + 6);
    chk("R4 no timeout when disabled", recov, 0);
    wr(8'h01);
    cyc(N + 6);
    chk("R4 no timeout without change", recov, 0);
    kick = 1; cyc(1); kick = 0;
    cyc(N + 6);
    chk("R5 kick while stopped no effect", recov, 0);
  endtask

  task automatic t_timeout;
    int h;
    change(3'd2);               // edge E0, now after E0
    chk("R3 freq updated armed", fsel, 2);
    h = 0;
    for (int i = 1; i < N - 1; i++) begin
      cyc(1);
      if (srst) h++;
    end                           // after E0+N-2
    cyc(1);                       // after E0+N-1
    chk("R4 not yet timed out", recov, 0);
    chk("R4 freq before timeout", fsel, 2);
    cyc(1);                       // after E0+N
    chk("R4 timeout due", recov, 1);
    chk("R6 recovery sel", fsel, RSEL);
    chk("R6 status and recovery bits", rdata, 8'h19);
    for (int i = 0; i < LEN + 2; i++) begin
      if (srst) h++;
      cyc(1);
    end
    chk("R10 no pulse when disabled", h, 0);
  endtask

  task automatic t_w1c;
    wr(8'h01);
    chk("R7 write 0 keeps status", rdata[3], 1);
    wr(8'h09);
    chk("R7 write 1 clears status", rdata[3], 0);
    chk("R7 still in recovery", recov, 1);
  endtask

  task automatic t_ignore;
    int h;
    wr(8'h05);
    change(3'd6);
    chk("R8 freq held", fsel, RSEL);
    count_high(LEN + 2, h);
    chk("R8 no pulse", h, 0);
  endtask

  task automatic t_leave;
    int h;
    wr(8'h04);
    chk("R9 recovery still set at write edge", recov, 1);
    cyc(1);
    chk("R9 recovery left", recov, 0);
    chk("R9 sel kept", fsel, RSEL);
    change(3'd1);
    chk("R9 new change accepted", fsel, 1);
    count_high(LEN + 3, h);
    chk("R11 change pulse length", h, LEN);
  endtask

  task automatic t_kick;
    wr(8'h01);
    change(3'd4);                // after E0
    for (int k = 0; k < 4; k++) begin
      cyc(N - 3);
      kick = 1; cyc(1); kick = 0;   // after kick edge K
    end
    chk("R5 no timeout while kicked", recov, 0);
    cyc(N - 1);
    chk("R5 not yet after last kick", recov, 0);
    cyc(1);
    chk("R5 timeout after last kick", recov, 1);
    wr(8'h00); cyc(1);
    chk("R9 cleared for next test", recov, 0);
  endtask

  task automatic t_pulse_wd;
    int h;
    wr(8'h03);
    change(3'd2);
    cyc(N - 1);
    chk("R10 pulse not before timeout", srst, 0);
    cyc(1);
    chk("R6 timed out", recov, 1);
    count_high(LEN + 3, h);
    chk("R10 timeout pulse length", h, LEN);
    wr(8'h00); cyc(1);
  endtask

  task automatic t_extend;
    int h;
    wr(8'h04);
    change(3'd3);
    cyc(1);
    change(3'd6);
    h = 3;                       // samples after E0, E0+1, E0+2 all high
    chk("R12 pulse high at retrigger", srst, 1);
    for (int i = 0; i < LEN + 3; i++) begin
      cyc(1);
      if (srst) h++;
    end
    chk("R12 merged pulse length", h, LEN + 2);
    chk("R3 last change", fsel, 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_regs();
    t_no_watchdog();
    wr(8'h00); cyc(1); wr(8'h01);
    t_timeout();
    t_w1c();
    t_ignore();
    t_leave();
    t_kick();
    t_pulse_wd();
    t_extend();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule